// File: doc/BRIEF.md
# Inversion-Retry Memory Write Controller

This block writes data words into a memory array whose cells can wear out and stick permanently at 0 or at 1. For each accepted request it encodes the word with a single-error-correcting Hamming code and writes it. It then reads the same address back and counts the cells that hold a value other than the one written. A stuck cell that happens to hold the written value does no harm. The write fails only when the number of wrong cells exceeds the correction capability `T_CAP`. After a failed first attempt the block makes one more write with the data complemented, so that cells stuck at the wrong value now hold the right one. A polarity bit records that the stored word is inverted.

Two storage modes are selected per request. In the integrated mode the polarity bit is part of the protected message, and the check bits are computed again over the complemented data plus polarity. In the unintegrated mode the second write is the bitwise complement of the whole first codeword, with no new encoding. The polarity is then stored in three extra cells beside the codeword and read through a majority vote. Each request ends with a one-cycle done pulse and a status code. A block that fails both attempts raises a defect flag that holds the block address until software acknowledges it.

Requests use a valid/ready handshake. `req_ready` is high only while the controller is idle. A requester that sees `req_ready` low must hold `req_valid`, address, data and mode unchanged until a cycle with both high. The block holds off further requests until the current one has completed. The array interface is a plain write strobe with a combinational read-back in the following cycle.

Top module: `wrc_inv_retry_ctrl`

## Requirements
- R1: `req_ready` is 1 only in the idle state. A request is taken on a rising edge with `req_valid` and `req_ready` both 1. `req_ready` then stays 0 until the edge after the done pulse.
- R2: In the cycle after acceptance, `mem_we` is 1 for one cycle at the request address with the first-attempt word, and the following cycle has `mem_we` 0.
  - Codeword layout: codeword bit p-1 holds Hamming position p. Check bits sit at the power-of-two positions, each equal to the XOR of the other positions that have that position bit set. Message bits fill the remaining positions in ascending order, starting with message bit 0.
  - Integrated first word: bits [12:0] hold the codeword over the 9-bit message {polarity=0, data}, with data in message bits 7:0. Bits [14:13] are 0.
  - Unintegrated first word: bits [11:0] hold the codeword over data. Bits [14:12] are the three polarity copies, all 0.
- R3: An attempt fails when more than `T_CAP` (1) codeword bits read back differ from the written word. Integrated mode compares bits [12:0] and unintegrated mode compares bits [11:0]. Stuck cells that hold the written value are not counted.
- R4: After a failed first attempt in integrated mode, the second write (two cycles after the first) is the codeword over {1, ~data}, with bits [14:13] at 0.
- R5: After a failed first attempt in unintegrated mode, the second write holds the bitwise complement of the first 12-bit codeword in bits [11:0] and 1 in all three polarity copies [14:12].
- R6: In unintegrated mode, an attempt also fails when the majority of the three read-back polarity copies differs from the polarity written. A single wrong copy is outvoted.
- R7: `done` pulses for exactly one cycle, with `done_status` set to 0 for first-try success, 1 for success after inversion, or 2 for defective. The pulse comes 3 cycles after acceptance when no retry is needed and 5 cycles after acceptance otherwise.
- R8: A failed second attempt sets `defect` and loads `defect_addr` on the same edge that starts the done pulse. The flag and address hold until a cycle with `defect_ack` at 1 clears them on the next edge. A later defect does not overwrite a held address unless it coincides with the acknowledge.
- R9: During and right after reset: `req_ready` 1, `mem_we` 0, `done` 0, `defect` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | ADDR_W (4) | Block address |
| req_data | input | DATA_W (8) | Data word to store |
| req_mode | input | 1 | 0 integrated, 1 unintegrated; sampled with the request |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W (4) | Array address for write and read-back |
| mem_wdata | output | PHYS_W (15) | Physical word written to the array |
| mem_rdata | input | PHYS_W (15) | Array contents at mem_addr, combinational |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 first try, 1 after inversion, 2 defective |
| defect | output | 1 | Defective block recorded |
| defect_addr | output | ADDR_W (4) | Address of the recorded defective block |
| defect_ack | input | 1 | Clears the defect record |

## Verification
The bench places stuck cells at chosen positions:

- **Matching stuck cells.** A pair of stuck cells that hold the written value must still give status 0. A design that counted stuck cells instead of wrong cells would retry here.
- **Two wrong data cells.** Two cells stuck at the wrong value in the data field must give an inverted retry. The bench checks its word exactly in each mode. A design that re-encoded in unintegrated mode, or forgot to flip the polarity inside the integrated message, would show a wrong `mem_wdata`.
- **Polarity copies.** With two polarity copies stuck at 0, the inverted retry must end as defective. A single stuck copy must be outvoted. A vote taken as OR or AND would swap these outcomes.
- **Defect record.** The bench repeats defects with and without acknowledges to catch an address overwritten while the flag is held.

// File: rtl/wrc_pkg.sv
package wrc_pkg;

  typedef enum logic [1:0] {
    WS_FIRST  = 2'd0,
    WS_RETRY  = 2'd1,
    WS_DEFECT = 2'd2
  } wr_status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WR1, S_CHK1, S_WR2, S_CHK2, S_DONE
  } wr_state_e;

  // number of Hamming check bits for a k-bit message
  function automatic int chk_bits(input int k);
    int r;
    r = 1;
    while ((1 << r) < k + r + 1) r++;
    return r;
  endfunction

  function automatic int cw_uni(input int d);
    return d + chk_bits(d);
  endfunction

  function automatic int cw_int(input int d);
    return d + 1 + chk_bits(d + 1);
  endfunction

  function automatic int phys_w(input int d);
    return (cw_int(d) > cw_uni(d) + 3) ? cw_int(d) : cw_uni(d) + 3;
  endfunction

endpackage

// File: rtl/wrc_hamming_enc.sv
module wrc_hamming_enc #(
  parameter int K = 9,
  parameter int N = 13
) (
  input  logic [K-1:0] msg,
  output logic [N-1:0] cw
);

  localparam int R = N - K;

  // positions (1-based) that check bit r covers, excluding check positions
  function automatic logic [N-1:0] cover_mask(input int r);
    logic [N-1:0] m;
    m = '0;
    for (int p = 1; p <= N; p++) begin
      if ((((p >> r) & 1) != 0) && ((p & (p - 1)) != 0)) m[p-1] = 1'b1;
    end
    return m;
  endfunction

  logic [N-1:0] placed;

  for (genvar b = 0; b < N; b++) begin : g_place
    localparam int P = b + 1;
    if ((P & (P - 1)) == 0) begin : g_chk_slot
      assign placed[b] = 1'b0;
    end else begin : g_msg_slot
      assign placed[b] = msg[P - 1 - $clog2(P + 1)];
    end
  end

  for (genvar b = 0; b < N; b++) begin : g_out
    localparam int P = b + 1;
    if ((P & (P - 1)) == 0) begin : g_par
      localparam logic [N-1:0] MASK = cover_mask($clog2(P));
      assign cw[b] = ^(placed & MASK);
    end else begin : g_dat
      assign cw[b] = placed[b];
    end
  end

  if (R < 1) begin : g_bad_param
    initial $display("wrc_hamming_enc: N must exceed K");
  end

endmodule

// File: rtl/wrc_popcount.sv
module wrc_popcount #(
  parameter int W = 15,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + {{(CW-1){1'b0}}, vec[i]};
    end
  end

endmodule

// File: rtl/wrc_vote3.sv
module wrc_vote3 (
  input  logic [2:0] copies,
  output logic       maj
);

  assign maj = (copies[0] & copies[1]) | (copies[0] & copies[2]) |
               (copies[1] & copies[2]);

endmodule

// File: rtl/wrc_inv_retry_ctrl.sv
module wrc_inv_retry_ctrl #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int T_CAP  = 1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [ADDR_W-1:0]                    req_addr,
  input  logic [DATA_W-1:0]                    req_data,
  input  logic                                 req_mode,
  output logic                                 mem_we,
  output logic [ADDR_W-1:0]                    mem_addr,
  output logic [wrc_pkg::phys_w(DATA_W)-1:0]   mem_wdata,
  input  logic [wrc_pkg::phys_w(DATA_W)-1:0]   mem_rdata,
  output logic                                 done,
  output logic [1:0]                           done_status,
  output logic                                 defect,
  output logic [ADDR_W-1:0]                    defect_addr,
  input  logic                                 defect_ack
);
  import wrc_pkg::*;

  localparam int CW_U   = cw_uni(DATA_W);
  localparam int CW_I   = cw_int(DATA_W);
  localparam int PHYS_W = phys_w(DATA_W);
  localparam int CNT_W  = $clog2(PHYS_W + 1);
  localparam logic [CNT_W-1:0] T_LIM = CNT_W'(T_CAP);

  wr_state_e         state_q;
  wr_status_e        status_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              mode_q;   // 1: unintegrated
  logic              pol_q;    // polarity of the attempt in flight
  logic              def_q;
  logic [ADDR_W-1:0] def_addr_q;

  // ---------------- encoders ----------------
  logic [DATA_W:0]   msg_int;
  logic [CW_I-1:0]   cw_int_w;
  logic [CW_U-1:0]   cw_uni_w;

  assign msg_int = pol_q ? {1'b1, ~data_q} : {1'b0, data_q};

  wrc_hamming_enc #(.K(DATA_W + 1), .N(CW_I)) u_enc_int (
    .msg (msg_int),
    .cw  (cw_int_w)
  );

  wrc_hamming_enc #(.K(DATA_W), .N(CW_U)) u_enc_uni (
    .msg (data_q),
    .cw  (cw_uni_w)
  );

  // ---------------- intended physical word ----------------
  logic [PHYS_W-1:0] word;
  logic [PHYS_W-1:0] cmp_mask;

  always_comb begin
    word     = '0;
    cmp_mask = '0;
    if (mode_q) begin
      word[CW_U-1:0]      = pol_q ? ~cw_uni_w : cw_uni_w;
      word[CW_U+2:CW_U]   = {3{pol_q}};
      cmp_mask[CW_U-1:0]  = '1;
    end else begin
      word[CW_I-1:0]      = cw_int_w;
      cmp_mask[CW_I-1:0]  = '1;
    end
  end

  // ---------------- read-back evaluation ----------------
  logic [CNT_W-1:0] wrong_cnt;
  logic             pol_vote;
  logic             attempt_ok;

  wrc_popcount #(.W(PHYS_W), .CW(CNT_W)) u_cnt (
    .vec (((mem_rdata ^ word) & cmp_mask)),
    .cnt (wrong_cnt)
  );

  wrc_vote3 u_vote (
    .copies (mem_rdata[CW_U+2:CW_U]),
    .maj    (pol_vote)
  );

  assign attempt_ok = (wrong_cnt <= T_LIM) && !(mode_q && (pol_vote != pol_q));

  // ---------------- sequencing ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      status_q <= WS_FIRST;
      addr_q   <= '0;
      data_q   <= '0;
      mode_q   <= 1'b0;
      pol_q    <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          data_q  <= req_data;
          mode_q  <= req_mode;
          pol_q   <= 1'b0;
          state_q <= S_WR1;
        end
        S_WR1:  state_q <= S_CHK1;
        S_CHK1: if (attempt_ok) begin
          status_q <= WS_FIRST;
          state_q  <= S_DONE;
        end else begin
          pol_q   <= 1'b1;
          state_q <= S_WR2;
        end
        S_WR2:  state_q <= S_CHK2;
        S_CHK2: begin
          status_q <= attempt_ok ? WS_RETRY : WS_DEFECT;
          state_q  <= S_DONE;
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  logic def_set;
  assign def_set = (state_q == S_CHK2) && !attempt_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      def_q      <= 1'b0;
      def_addr_q <= '0;
    end else if (def_set && (!def_q || defect_ack)) begin
      def_q      <= 1'b1;
      def_addr_q <= addr_q;
    end else if (defect_ack) begin
      def_q      <= 1'b0;
    end
  end

  assign req_ready   = (state_q == S_IDLE);
  assign mem_we      = (state_q == S_WR1) || (state_q == S_WR2);
  assign mem_addr    = addr_q;
  assign mem_wdata   = word;
  assign done        = (state_q == S_DONE);
  assign done_status = status_q;
  assign defect      = def_q;
  assign defect_addr = def_addr_q;

endmodule

// File: rtl/wrc_checker.sv
module wrc_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               req_valid,
  input logic                               req_ready,
  input logic                               mem_we,
  input logic [wrc_pkg::phys_w(DATA_W)-1:0] mem_wdata,
  input logic                               done,
  input logic [1:0]                         done_status,
  input logic                               defect,
  input logic [ADDR_W-1:0]                  defect_addr,
  input logic                               defect_ack,
  input logic                               mode_q
);
  localparam int CW_U   = wrc_pkg::cw_uni(DATA_W);
  localparam int CW_I   = wrc_pkg::cw_int(DATA_W);
  localparam int PHYS_W = wrc_pkg::phys_w(DATA_W);

  AST_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !req_ready); // R1
  AST_WRITE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_we); // R2
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_status != 2'd3)); // R7
  AST_DEFECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (defect && !defect_ack) |=> (defect && $stable(defect_addr))); // R8
  AST_POL_COPIES_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mode_q) |-> ($countones(mem_wdata[CW_U+2:CW_U]) == 0 ||
                            $countones(mem_wdata[CW_U+2:CW_U]) == 3)); // R5

  if (PHYS_W > CW_I) begin : g_pad
    AST_INT_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !mode_q) |-> (mem_wdata[PHYS_W-1:CW_I] == '0)); // R4
  end

endmodule

bind wrc_inv_retry_ctrl wrc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wrc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .mem_we      (mem_we),
  .mem_wdata   (mem_wdata),
  .done        (done),
  .done_status (done_status),
  .defect      (defect),
  .defect_addr (defect_addr),
  .defect_ack  (defect_ack),
  .mode_q      (mode_q)
);

// File: tb/tb_wrc_inv_retry_ctrl.sv
module tb_wrc_inv_retry_ctrl;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int T  = 1;
  localparam int PW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          req_mode = 1'b0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [PW-1:0] mem_wdata;
  logic [PW-1:0] mem_rdata;
  logic          done;
  logic [1:0]    done_status;
  logic          defect;
  logic [AW-1:0] defect_addr;
  logic          defect_ack = 1'b0;

  always #4 clk = ~clk;

  wrc_inv_retry_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_CAP(T)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_mode(req_mode),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .done_status(done_status),
    .defect(defect), .defect_addr(defect_addr), .defect_ack(defect_ack)
  );

  // ---------------- array with stuck cells ----------------
  logic [PW-1:0] arr [16];
  logic [PW-1:0] smask [16];
  logic [PW-1:0] sval [16];

  initial for (int i = 0; i < 16; i++) begin
    arr[i] = '0; smask[i] = '0; sval[i] = '0;
  end

  always @(posedge clk) if (mem_we) arr[mem_addr] <= mem_wdata;
  assign mem_rdata = (arr[mem_addr] & ~smask[mem_addr]) | (sval[mem_addr] & smask[mem_addr]);

  // ---------------- reference functions ----------------
  function automatic logic [15:0] ham(input logic [8:0] msg, input int k);
    logic [15:0] c;
    int r, n, mi, p, q;
    logic par;
    r = 1;
    while ((1 << r) < k + r + 1) r++;
    n = k + r;
    c = '0; mi = 0;
    for (p = 1; p <= n; p++) begin
      if ((p & (p - 1)) != 0) begin c[p-1] = msg[mi]; mi++; end
    end
    for (q = 0; q < r; q++) begin
      par = 1'b0;
      for (p = 1; p <= n; p++)
        if (((p >> q) & 1) != 0 && p != (1 << q)) par ^= c[p-1];
      c[(1 << q) - 1] = par;
    end
    return c;
  endfunction

  function automatic logic [PW-1:0] exp_word(input logic md, input logic [7:0] d, input logic pl);
    logic [15:0] c;
    logic [PW-1:0] w;
    w = '0;
    if (!md) begin
      c = ham({pl, pl ? ~d : d}, 9);
      w[12:0] = c[12:0];
    end else begin
      c = ham({1'b0, d}, 8);
      w[11:0] = pl ? ~c[11:0] : c[11:0];
      w[14:12] = {3{pl}};
    end
    return w;
  endfunction

  function automatic logic attempt_ok(input logic md, input logic [7:0] d,
                                      input logic pl, input logic [3:0] a);
    logic [PW-1:0] w, rb, msk;
    w   = exp_word(md, d, pl);
    rb  = (w & ~smask[a]) | (sval[a] & smask[a]);
    msk = md ? 15'h0FFF : 15'h1FFF;
    if ($countones((rb ^ w) & msk) > T) return 1'b0;
    if (md && (($countones(rb[14:12]) >= 2) != pl)) return 1'b0;
    return 1'b1;
  endfunction

  // ---------------- cycle model ----------------
  int          phase;
  logic [3:0]  m_addr;
  logic [7:0]  m_data;
  logic        m_mode, m_pol, m_def, newdef;
  logic [1:0]  m_stat;
  logic [3:0]  m_defa;

  always @(posedge clk) begin
    if (!rst_n) begin
      phase = 0; m_def = 0; m_defa = 0; m_stat = 0; m_pol = 0;
      m_addr = 0; m_data = 0; m_mode = 0;
    end else begin
      newdef = 1'b0;
      case (phase)
        0: if (req_valid) begin
             m_addr = req_addr; m_data = req_data; m_mode = req_mode;
             m_pol = 1'b0; phase = 1;
           end
        1: phase = 2;
        2: if (attempt_ok(m_mode, m_data, 1'b0, m_addr)) begin
             m_stat = 2'd0; phase = 5;
           end else begin
             m_pol = 1'b1; phase = 3;
           end
        3: phase = 4;
        4: begin
             if (attempt_ok(m_mode, m_data, 1'b1, m_addr)) m_stat = 2'd1;
             else begin m_stat = 2'd2; newdef = 1'b1; end
             phase = 5;
           end
        default: phase = 0;
      endcase
      if (newdef && (!m_def || defect_ack)) begin
        m_def = 1'b1; m_defa = m_addr;
      end else if (defect_ack) m_def = 1'b0;
    end
  end

  // ---------------- comparison ----------------
  int n_cmp = 0;
  int n_bad = 0;
  int seen [3];
  initial for (int i = 0; i < 3; i++) seen[i] = 0;

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    logic ewe;
    ewe = (phase == 1) || (phase == 3);
    check(req_ready === (phase == 0), (rst_n ? "R1" : "R9"), "req_ready", 32'(req_ready), 32'(phase == 0));
    check(mem_we === ewe, (rst_n ? "R2" : "R9"), "mem_we", 32'(mem_we), 32'(ewe));
    if (rst_n && ewe) begin
      logic [PW-1:0] ew;
      ew = exp_word(m_mode, m_data, m_pol);
      check(mem_wdata === ew, (phase == 1) ? "R2" : (m_mode ? "R5" : "R4"),
            "mem_wdata", 32'(mem_wdata), 32'(ew));
      check(mem_addr === m_addr, "R2", "mem_addr", 32'(mem_addr), 32'(m_addr));
    end
    check(done === (phase == 5), (rst_n ? "R7" : "R9"), "done", 32'(done), 32'(phase == 5));
    if (rst_n && phase == 5) begin
      check(done_status === m_stat, (m_mode ? "R6" : "R3"), "done_status",
            32'(done_status), 32'(m_stat));
      if (m_stat < 3) seen[m_stat]++;
    end
    check(defect === m_def, (rst_n ? "R8" : "R9"), "defect", 32'(defect), 32'(m_def));
    if (rst_n && m_def)
      check(defect_addr === m_defa, "R8", "defect_addr", 32'(defect_addr), 32'(m_defa));
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [3:0] a, input logic [7:0] d, input logic md);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d; req_mode = md;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    while (phase != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic stuck(input logic [3:0] a, input logic [PW-1:0] m, input logic [PW-1:0] v);
    smask[a] = m; sval[a] = v;
  endtask

  task automatic ack_pulse();
    @(negedge clk); defect_ack = 1'b1;
    @(negedge clk); defect_ack = 1'b0;
  endtask

  bit ended = 0;
  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);         // R9 reset state compared each cycle
    rst_n = 1'b1;
    // clean block, both modes: R2, R7
    send(4'd0, 8'hA5, 1'b0); finish_run();
    send(4'd0, 8'h3C, 1'b1); finish_run();
    // single wrong cell tolerated: R3
    stuck(4'd1, 15'h0004, 15'h0004);
    send(4'd1, 8'h00, 1'b0); finish_run();
    // two stuck cells holding the written value: R3
    stuck(4'd2, 15'h0014, 15'h0014);
    send(4'd2, 8'hFF, 1'b0); finish_run();
    // two wrong data cells -> inverted retry, integrated R4 then unintegrated R5
    send(4'd2, 8'h00, 1'b0); finish_run();
    send(4'd2, 8'h00, 1'b1); finish_run();
    // two polarity copies stuck at 0 plus failing codeword -> defect R6, R8
    stuck(4'd4, 15'h3014, 15'h0014);
    send(4'd4, 8'h00, 1'b1); finish_run();
    // one polarity copy stuck: outvoted, retry succeeds R6
    stuck(4'd5, 15'h4014, 15'h0014);
    send(4'd5, 8'h00, 1'b1); finish_run();
    // second defect while flagged keeps first address R8
    stuck(4'd6, 15'h0FFF, 15'h0AAA);
    send(4'd6, 8'h5A, 1'b1); finish_run();
    ack_pulse();
    send(4'd6, 8'h5A, 1'b1); finish_run();
    // back-to-back requests exercising back-pressure R1
    send(4'd7, 8'h11, 1'b0);
    send(4'd8, 8'h22, 1'b1);
    send(4'd2, 8'h00, 1'b1);
    finish_run();
    ack_pulse();
    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [3:0] a;
      logic [PW-1:0] m;
      a = 4'($urandom_range(0, 15));
      m = '0;
      for (int j = 0; j < int'($urandom_range(0, 4)); j++) m[$urandom_range(0, PW - 1)] = 1'b1;
      stuck(a, m, PW'($urandom));
      send(a, 8'($urandom), 1'($urandom));
      if ($urandom_range(0, 3) == 0) ack_pulse();
    end
    finish_run();
    check(seen[0] > 0, "R3", "first-try outcomes seen", 32'(seen[0]), 32'(1));
    check(seen[1] > 0, "R4", "retry outcomes seen", 32'(seen[1]), 32'(1));
    check(seen[2] > 0, "R8", "defect outcomes seen", 32'(seen[2]), 32'(1));
    summary();
  end

endmodule